// File: doc/BRIEF.md
# ADC Scan Sequence Controller

This block steps a multiplexed analog-to-digital converter through a list of eight sample slots. Each slot names one of eight analog inputs, and the same input may appear in several slots. A per-slot mask drops slots from the scan. Each even/odd pair of inputs (0/1, 2/3, 4/5, 6/7) has its own enable bit for differential mode. When a slot is converted, the block checks that bit for the slot's pair and decides whether the measurement is single-ended or differential.

Conversions go to one or two converter cores over a request/done handshake. In sequential mode, converter A takes every enabled slot in ascending order. In parallel mode, converter A takes slots 0–3 while converter B takes slots 4–7 at the same time. A scan is launched by a software start strobe or by an external sync pulse when sync triggering is enabled. Each returned result is stored under its slot number together with a differential tag. Each converter lane raises its own end-of-scan pulse.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset `busy_o`, both end-of-scan outputs and both request outputs are 0, and every result word and tag is 0.
- R2: A slot's 3-bit input index sits at `slot_sel_i[3*s +: 3]`. Any slot may name any input, and repeats are allowed.
- R3: A slot whose bit in `slot_dis_i` is 1 is never converted, and its stored result and tag keep their previous values.
- R4: A slot is differential when `pair_diff_i[sel>>1]` is 1. A differential slot is sent to its converter with the pair's even input as channel and the diff flag set. A single-ended slot is sent with channel `sel` and the diff flag clear.
- R5: When `par_mode_i` is 0, converter A converts the enabled slots one at a time in ascending slot order. `eos_a_o` pulses once after the last slot, and `eos_b_o` stays 0.
- R6: When `par_mode_i` is 1, converter A handles slots 0–3 and converter B handles slots 4–7 concurrently. Each converter pulses its own end-of-scan once.
- R7: A one-cycle `start_i` strobe is held in a self-clearing start flag. The first conversion request appears two clock edges after the strobe is sampled.
- R8: With `sync_en_i` at 1, a `sync_i` pulse starts a scan, with the request one edge later. With `sync_en_i` at 0, `sync_i` is ignored.
- R9: A start strobe or sync pulse that arrives while `busy_o` is 1 is ignored. No extra conversions and no extra end-of-scan pulse result.
- R10: A lane whose slot range is fully disabled issues no request and pulses its end-of-scan at the same edge where a request would otherwise have appeared.
- R11: At the edge where a converter's done is 1, its data is written into result word `res_data_o[12*s +: 12]` and tag `res_diff_o[s]` for the slot being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel_i | input | 24 | Input index per slot, 3 bits each |
| slot_dis_i | input | 8 | Per-slot disable mask |
| pair_diff_i | input | 4 | Differential enable per input pair |
| par_mode_i | input | 1 | 0 sequential, 1 parallel |
| sync_en_i | input | 1 | Enables sync-pulse triggering |
| start_i | input | 1 | Software start strobe |
| sync_i | input | 1 | External sync pulse |
| cva_req_o | output | 1 | Converter A request |
| cva_chan_o | output | 3 | Converter A channel |
| cva_diff_o | output | 1 | Converter A differential flag |
| cva_done_i | input | 1 | Converter A done pulse |
| cva_data_i | input | 12 | Converter A result |
| cvb_req_o | output | 1 | Converter B request |
| cvb_chan_o | output | 3 | Converter B channel |
| cvb_diff_o | output | 1 | Converter B differential flag |
| cvb_done_i | input | 1 | Converter B done pulse |
| cvb_data_i | input | 12 | Converter B result |
| busy_o | output | 1 | A scan is in progress |
| eos_a_o | output | 1 | End-of-scan pulse, lane A |
| eos_b_o | output | 1 | End-of-scan pulse, lane B |
| res_data_o | output | 96 | Result words, 12 bits per slot |
| res_diff_o | output | 8 | Differential tag per slot |

## Verification
A start strobe reaches the request outputs, or an empty lane's end-of-scan, on the second edge after it is sampled; a sync pulse reaches them on the first. The bench samples at exactly those points, half a period after the edge. Result words change at the edge carrying done, and end-of-scan follows at that same edge. The bench therefore only compares results and counts pulses after `busy_o` has fallen and a few settling cycles have passed. The converter model's returned data carries its channel, diff flag and per-lane conversion count. Each stored word then shows which slot went where and in what order.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_CONV = 1'b1
  } lane_st_e;
endpackage

// File: rtl/adc_slot_resolve.sv
module adc_slot_resolve #(
  parameter int NUM_SLOTS  = 8,
  parameter int NUM_INPUTS = 8,
  parameter int SEL_W      = 3
) (
  input  logic [NUM_SLOTS*SEL_W-1:0] slot_sel_i,
  input  logic [NUM_INPUTS/2-1:0]    pair_diff_i,
  output logic [NUM_SLOTS-1:0]       slot_diff_o,
  output logic [NUM_SLOTS*SEL_W-1:0] slot_chan_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SEL_W-1:0] sel;
    logic             dif;
    assign sel = slot_sel_i[s*SEL_W +: SEL_W];
    assign dif = pair_diff_i[sel >> 1];
    assign slot_diff_o[s] = dif;
    assign slot_chan_o[s*SEL_W +: SEL_W] = dif ? {sel[SEL_W-1:1], 1'b0} : sel;
  end
endmodule

// File: rtl/adc_scan_lane.sv
module adc_scan_lane
  import adc_scan_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SEL_W     = 3,
  parameter int RES_W     = 12,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go_i,
  input  logic [IDX_W-1:0]           lo_i,
  input  logic [IDX_W-1:0]           hi_i,
  input  logic [NUM_SLOTS-1:0]       slot_dis_i,
  input  logic [NUM_SLOTS-1:0]       slot_diff_i,
  input  logic [NUM_SLOTS*SEL_W-1:0] slot_chan_i,
  input  logic                       cv_done_i,
  input  logic [RES_W-1:0]           cv_data_i,
  output logic                       cv_req_o,
  output logic [SEL_W-1:0]           cv_chan_o,
  output logic                       cv_diff_o,
  output logic                       wr_o,
  output logic [IDX_W-1:0]           wr_idx_o,
  output logic [RES_W-1:0]           wr_data_o,
  output logic                       wr_diff_o,
  output logic                       eos_o,
  output logic                       busy_o
);
  lane_st_e         st_q, st_d;
  logic [IDX_W-1:0] cur_q, cur_d;
  logic             cur_en;
  logic             eos_q, eos_d;

  // search for the lowest enabled slot in [from, hi]
  function automatic logic [IDX_W:0] pick(input int from, input int hi,
                                          input logic [NUM_SLOTS-1:0] dis);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (i >= from && i <= hi && !dis[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  logic [IDX_W:0] first_hit, next_hit;
  assign first_hit = pick(int'(lo_i), int'(hi_i), slot_dis_i);
  assign next_hit  = pick(int'(cur_q) + 1, int'(hi_i), slot_dis_i);

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    cur_en = 1'b0;
    eos_d  = 1'b0;
    case (st_q)
      LN_IDLE: if (go_i) begin
        if (first_hit[IDX_W]) begin
          st_d   = LN_CONV;
          cur_d  = first_hit[IDX_W-1:0];
          cur_en = 1'b1;
        end else begin
          eos_d = 1'b1;
        end
      end
      LN_CONV: if (cv_done_i) begin
        if (next_hit[IDX_W]) begin
          cur_d  = next_hit[IDX_W-1:0];
          cur_en = 1'b1;
        end else begin
          st_d  = LN_IDLE;
          eos_d = 1'b1;
        end
      end
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cur_q <= '0;
      eos_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      eos_q <= eos_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign busy_o    = (st_q == LN_CONV);
  assign cv_req_o  = busy_o;
  assign cv_chan_o = slot_chan_i[cur_q*SEL_W +: SEL_W];
  assign cv_diff_o = slot_diff_i[cur_q];
  assign wr_o      = busy_o && cv_done_i;
  assign wr_idx_o  = cur_q;
  assign wr_data_o = cv_data_i;
  assign wr_diff_o = slot_diff_i[cur_q];
  assign eos_o     = eos_q;

  a_r3_skip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_CONV) |-> !slot_dis_i[cur_q]);
  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_CONV && cv_done_i) |=> (st_q == LN_IDLE || cur_q > $past(cur_q)));
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_CONV) |-> (cur_q >= lo_i && cur_q <= hi_i));
  a_r9_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_CONV && !cv_done_i) |=> (st_q == LN_CONV && $stable(cur_q)));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int RES_W     = 12,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wa_i,
  input  logic [IDX_W-1:0]           wa_idx_i,
  input  logic [RES_W-1:0]           wa_data_i,
  input  logic                       wa_diff_i,
  input  logic                       wb_i,
  input  logic [IDX_W-1:0]           wb_idx_i,
  input  logic [RES_W-1:0]           wb_data_i,
  input  logic                       wb_diff_i,
  output logic [NUM_SLOTS*RES_W-1:0] res_data_o,
  output logic [NUM_SLOTS-1:0]       res_diff_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_word
    logic             hit_a, hit_b, en;
    logic [RES_W-1:0] data_q, data_d;
    logic             diff_q, diff_d;
    assign hit_a  = wa_i && (wa_idx_i == IDX_W'(s));
    assign hit_b  = wb_i && (wb_idx_i == IDX_W'(s));
    assign en     = hit_a || hit_b;
    assign data_d = hit_a ? wa_data_i : wb_data_i;
    assign diff_d = hit_a ? wa_diff_i : wb_diff_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        diff_q <= 1'b0;
      end else if (en) begin
        data_q <= data_d;
        diff_q <= diff_d;
      end
    end
    assign res_data_o[s*RES_W +: RES_W] = data_q;
    assign res_diff_o[s] = diff_q;
  end

  a_r11_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_i && wb_i && wa_idx_i == wb_idx_i));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int NUM_SLOTS  = 8,
  parameter int NUM_INPUTS = 8,
  parameter int SEL_W      = 3,
  parameter int RES_W      = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SLOTS*SEL_W-1:0] slot_sel_i,
  input  logic [NUM_SLOTS-1:0]       slot_dis_i,
  input  logic [NUM_INPUTS/2-1:0]    pair_diff_i,
  input  logic                       par_mode_i,
  input  logic                       sync_en_i,
  input  logic                       start_i,
  input  logic                       sync_i,
  output logic                       cva_req_o,
  output logic [SEL_W-1:0]           cva_chan_o,
  output logic                       cva_diff_o,
  input  logic                       cva_done_i,
  input  logic [RES_W-1:0]           cva_data_i,
  output logic                       cvb_req_o,
  output logic [SEL_W-1:0]           cvb_chan_o,
  output logic                       cvb_diff_o,
  input  logic                       cvb_done_i,
  input  logic [RES_W-1:0]           cvb_data_i,
  output logic                       busy_o,
  output logic                       eos_a_o,
  output logic                       eos_b_o,
  output logic [NUM_SLOTS*RES_W-1:0] res_data_o,
  output logic [NUM_SLOTS-1:0]       res_diff_o
);
  localparam int IDX_W  = $clog2(NUM_SLOTS);
  localparam int NLANES = 2;
  localparam logic [IDX_W-1:0] HALF_LO = IDX_W'(NUM_SLOTS / 2);
  localparam logic [IDX_W-1:0] HALF_HI = IDX_W'(NUM_SLOTS / 2 - 1);
  localparam logic [IDX_W-1:0] TOP_HI  = IDX_W'(NUM_SLOTS - 1);

  logic start_q;
  logic go;
  logic [NUM_SLOTS-1:0]       slot_diff;
  logic [NUM_SLOTS*SEL_W-1:0] slot_chan;

  logic             ln_go   [NLANES];
  logic [IDX_W-1:0] ln_lo   [NLANES];
  logic [IDX_W-1:0] ln_hi   [NLANES];
  logic             ln_done [NLANES];
  logic [RES_W-1:0] ln_din  [NLANES];
  logic             ln_req  [NLANES];
  logic [SEL_W-1:0] ln_chan [NLANES];
  logic             ln_dif  [NLANES];
  logic             ln_wr   [NLANES];
  logic [IDX_W-1:0] ln_widx [NLANES];
  logic [RES_W-1:0] ln_wdat [NLANES];
  logic             ln_wdif [NLANES];
  logic             ln_eos  [NLANES];
  logic             ln_busy [NLANES];

  // start flag clears itself one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_i;
  end

  assign busy_o = ln_busy[0] || ln_busy[1];
  assign go     = (start_q || (sync_en_i && sync_i)) && !busy_o;

  assign ln_go[0]   = go;
  assign ln_lo[0]   = '0;
  assign ln_hi[0]   = par_mode_i ? HALF_HI : TOP_HI;
  assign ln_done[0] = cva_done_i;
  assign ln_din[0]  = cva_data_i;
  assign ln_go[1]   = go && par_mode_i;
  assign ln_lo[1]   = HALF_LO;
  assign ln_hi[1]   = TOP_HI;
  assign ln_done[1] = cvb_done_i;
  assign ln_din[1]  = cvb_data_i;

  adc_slot_resolve #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_INPUTS(NUM_INPUTS), .SEL_W(SEL_W)
  ) u_resolve (
    .slot_sel_i (slot_sel_i),
    .pair_diff_i(pair_diff_i),
    .slot_diff_o(slot_diff),
    .slot_chan_o(slot_chan)
  );

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    adc_scan_lane #(
      .NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W), .RES_W(RES_W)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (ln_go[l]),
      .lo_i       (ln_lo[l]),
      .hi_i       (ln_hi[l]),
      .slot_dis_i (slot_dis_i),
      .slot_diff_i(slot_diff),
      .slot_chan_i(slot_chan),
      .cv_done_i  (ln_done[l]),
      .cv_data_i  (ln_din[l]),
      .cv_req_o   (ln_req[l]),
      .cv_chan_o  (ln_chan[l]),
      .cv_diff_o  (ln_dif[l]),
      .wr_o       (ln_wr[l]),
      .wr_idx_o   (ln_widx[l]),
      .wr_data_o  (ln_wdat[l]),
      .wr_diff_o  (ln_wdif[l]),
      .eos_o      (ln_eos[l]),
      .busy_o     (ln_busy[l])
    );
  end

  assign cva_req_o  = ln_req[0];
  assign cva_chan_o = ln_chan[0];
  assign cva_diff_o = ln_dif[0];
  assign cvb_req_o  = ln_req[1];
  assign cvb_chan_o = ln_chan[1];
  assign cvb_diff_o = ln_dif[1];
  assign eos_a_o    = ln_eos[0];
  assign eos_b_o    = ln_eos[1];

  adc_result_bank #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wa_i      (ln_wr[0]),
    .wa_idx_i  (ln_widx[0]),
    .wa_data_i (ln_wdat[0]),
    .wa_diff_i (ln_wdif[0]),
    .wb_i      (ln_wr[1]),
    .wb_idx_i  (ln_widx[1]),
    .wb_data_i (ln_wdat[1]),
    .wb_diff_i (ln_wdif[1]),
    .res_data_o(res_data_o),
    .res_diff_o(res_diff_o)
  );

  a_r5_no_eos_b_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode_i && !$past(par_mode_i)) |-> !eos_b_o);
  a_r8_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_q && !(sync_en_i && sync_i)) |=> !busy_o);
endmodule

// File: tb/adc_scan_ctrl_tb.sv
module adc_scan_ctrl_tb;
  localparam int LAT = 3;

  logic        clk, rst_n;
  logic [23:0] slot_sel;
  logic [7:0]  slot_dis;
  logic [3:0]  pair_diff;
  logic        par_mode, sync_en, start, sync;
  logic        cva_req, cva_diff, cvb_req, cvb_diff;
  logic [2:0]  cva_chan, cvb_chan;
  logic        cva_done, cvb_done;
  logic [11:0] cva_data, cvb_data;
  logic        busy, eos_a, eos_b;
  logic [95:0] res_data;
  logic [7:0]  res_diff;

  int tests = 0, fails = 0;
  logic mclr;

  adc_scan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .slot_sel_i(slot_sel), .slot_dis_i(slot_dis),
    .pair_diff_i(pair_diff), .par_mode_i(par_mode), .sync_en_i(sync_en),
    .start_i(start), .sync_i(sync),
    .cva_req_o(cva_req), .cva_chan_o(cva_chan), .cva_diff_o(cva_diff),
    .cva_done_i(cva_done), .cva_data_i(cva_data),
    .cvb_req_o(cvb_req), .cvb_chan_o(cvb_chan), .cvb_diff_o(cvb_diff),
    .cvb_done_i(cvb_done), .cvb_data_i(cvb_data),
    .busy_o(busy), .eos_a_o(eos_a), .eos_b_o(eos_b),
    .res_data_o(res_data), .res_diff_o(res_diff)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // converter models: fixed latency, data = {diff, chan, per-lane count}
  int na, nb, ea, eb;
  logic ba, bb, dfa, dfb;
  int ca, cb;
  logic [2:0] cha, chb;
  logic [7:0] tga, tgb;
  assign cva_data = {dfa, cha, tga};
  assign cvb_data = {dfb, chb, tgb};

  always @(posedge clk) begin
    if (!rst_n) begin
      na <= 0; ea <= 0; ba <= 0; ca <= 0; cva_done <= 0; dfa <= 0; cha <= 0; tga <= 0;
    end else begin
      cva_done <= 1'b0;
      if (mclr) begin na <= 0; ea <= 0; end
      else if (eos_a) ea <= ea + 1;
      if (!ba && cva_req && !cva_done) begin
        ba <= 1'b1; ca <= LAT; cha <= cva_chan; dfa <= cva_diff; tga <= 8'(na);
        if (!mclr) na <= na + 1;
      end else if (ba) begin
        ca <= ca - 1;
        if (ca == 1) begin ba <= 1'b0; cva_done <= 1'b1; end
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      nb <= 0; eb <= 0; bb <= 0; cb <= 0; cvb_done <= 0; dfb <= 0; chb <= 0; tgb <= 0;
    end else begin
      cvb_done <= 1'b0;
      if (mclr) begin nb <= 0; eb <= 0; end
      else if (eos_b) eb <= eb + 1;
      if (!bb && cvb_req && !cvb_done) begin
        bb <= 1'b1; cb <= LAT; chb <= cvb_chan; dfb <= cvb_diff; tgb <= 8'(nb);
        if (!mclr) nb <= nb + 1;
      end else if (bb) begin
        cb <= cb - 1;
        if (cb == 1) begin bb <= 1'b0; cvb_done <= 1'b1; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [11:0] exp_res [8];
  logic        exp_dif [8];

  task automatic clear_model();
    @(negedge clk); mclr = 1'b1;
    @(negedge clk); mclr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // full scan with independent expectation
  task automatic run_scan(input bit par, input logic [7:0] mask, input int pat,
                          input bit use_sync);
    int cnt_a, cnt_b;
    bit any_a, any_b;
    logic [2:0] sel;
    logic       d;
    cnt_a = 0; cnt_b = 0; any_a = 0; any_b = 0;
    par_mode = par; slot_dis = mask;
    pair_diff = mask[3:0] ^ mask[7:4] ^ 4'(pat * 5);
    for (int s = 0; s < 8; s++)
      slot_sel[s*3 +: 3] = (pat == 0) ? 3'(s) : (pat == 1) ? 3'(((s >> 1) * 2 + 1)) : 3'(7 - s);
    clear_model();
    for (int s = 0; s < 8; s++) if (!mask[s]) begin
      if (par && s >= 4) any_b = 1; else any_a = 1;
    end
    if (use_sync) begin
      sync_en = 1'b1;
      @(negedge clk); sync = 1'b1;
      @(posedge clk); #1;
      check(cva_req == any_a, "R8", "sync to req_a", cva_req, any_a);
      @(negedge clk); sync = 1'b0;
    end else begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(posedge clk); #1;
      check(cva_req == any_a, "R7", "req_a two edges after start", cva_req, any_a);
      if (!any_a) check(eos_a == 1'b1, "R10", "empty lane A eos", eos_a, 1);
      if (par) begin
        check(cvb_req == any_b, "R6", "req_b with req_a", cvb_req, any_b);
        if (!any_b) check(eos_b == 1'b1, "R10", "empty lane B eos", eos_b, 1);
      end
    end
    wait_idle();
    sync_en = 1'b0;
    for (int s = 0; s < 8; s++) if (!mask[s]) begin
      sel = slot_sel[s*3 +: 3];
      d   = pair_diff[sel >> 1];
      exp_dif[s] = d;
      if (par && s >= 4) begin
        exp_res[s] = {d, d ? {sel[2:1], 1'b0} : sel, 8'(cnt_b)}; cnt_b++;
      end else begin
        exp_res[s] = {d, d ? {sel[2:1], 1'b0} : sel, 8'(cnt_a)}; cnt_a++;
      end
    end
    for (int s = 0; s < 8; s++) begin
      check(res_data[s*12 +: 12] == exp_res[s], mask[s] ? "R3" : (par ? "R6" : "R5"),
            "result word", res_data[s*12 +: 12], exp_res[s]);
      check(res_diff[s] == exp_dif[s], "R4", "diff tag", res_diff[s], exp_dif[s]);
    end
    check(na == cnt_a, "R11", "conversions on A", na, cnt_a);
    check(nb == cnt_b, par ? "R6" : "R5", "conversions on B", nb, cnt_b);
    check(ea == 1, "R5", "eos_a pulses", ea, 1);
    check(eb == (par ? 1 : 0), "R6", "eos_b pulses", eb, par ? 1 : 0);
  endtask

  bit fin = 0;
  initial begin
    rst_n = 0; mclr = 0; slot_sel = '0; slot_dis = '0; pair_diff = '0;
    par_mode = 0; sync_en = 0; start = 0; sync = 0;
    for (int s = 0; s < 8; s++) begin exp_res[s] = '0; exp_dif[s] = 1'b0; end
    repeat (3) @(negedge clk);
    check(busy == 0 && eos_a == 0 && eos_b == 0, "R1", "idle after reset", {busy, eos_a, eos_b}, 0);
    check(cva_req == 0 && cvb_req == 0, "R1", "no request in reset", {cva_req, cvb_req}, 0);
    check(res_data == '0 && res_diff == '0, "R1", "results cleared", res_data[31:0], 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6 R10 R11: sweep all masks, both modes, three select patterns
    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 256; m++)
        for (int md = 0; md < 2; md++)
          run_scan(md[0], 8'(m), p, 1'b0);

    // R8: sync ignored when not enabled
    clear_model();
    slot_dis = 8'h00; par_mode = 0; sync_en = 0;
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    repeat (4) @(negedge clk);
    check(busy == 0 && na == 0, "R8", "sync without enable", na, 0);
    // R8: sync with enable
    run_scan(1'b1, 8'h21, 1, 1'b1);
    run_scan(1'b0, 8'h5a, 2, 1'b1);

    // R9: retrigger during busy is ignored
    run_scan(1'b0, 8'h00, 0, 1'b0);
    clear_model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; sync_en = 1'b1; sync = 1'b1;
    @(negedge clk); start = 1'b0; sync = 1'b0;
    repeat (6) @(negedge clk); sync_en = 1'b1; sync = 1'b1;
    @(negedge clk); sync = 1'b0; sync_en = 1'b0;
    wait_idle();
    check(na == 8, "R9", "conversions with retrigger", na, 8);
    check(ea == 1, "R9", "eos pulses with retrigger", ea, 1);

    fin = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!fin) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule